// File: doc/BRIEF.md
# Single-Wire Bus Bit Engine

This block is the bit-level master of a bus built on one open-drain wire with an external pull-up. On a host command it produces one of four waveforms: a reset with presence detection, a write of a 1, a write of a 0, or a read of one bit. Each waveform comes from a microsecond timebase, and the tick for that timebase is derived from the clock frequency parameter. Byte framing, device addressing and checksums belong to the layer above. That layer issues one command at a time and waits for the completion pulse.

The host puts a command code and, for a write, the data bit on the inputs and strobes `start`. `busy` stays high for the whole waveform, including the released recovery tail. `done` pulses once at the end. The block drives the wire only through `busLow`, which enables an open-drain pull-down. The wire level returns on `busIn` and passes through a two-stage synchronizer before it is sampled. The last sampled read bit and the presence result stay on `rdBit` and `presence` until the sampling step of a later command of the same kind.

Top module: `swbus_master`

## Requirements
- R1: A reset command (cmd 2'b00) pulls the wire low for 480 µs and then releases it. `busy` covers 960 µs in total.
- R2: During a reset, the wire is sampled 70 µs after release. `presence` becomes 1 if the wire is low at that point and 0 if it is high.
- R3: A write command (cmd 2'b01) with `dataBit` = 1 pulls the wire low for 6 µs and then releases it. The whole command lasts 70 µs.
- R4: A write command with `dataBit` = 0 holds the wire low for 65 µs. The wire is then released for 5 µs before the command ends.
- R5: A read command (cmd 2'b10) pulls the wire low for 6 µs and samples the wire 12 µs after the start. `rdBit` is 1 for a high sample and 0 for a low sample. If a slave pulls the wire low only after the sample point, the result is 1.
- R6: After reset `busy`, `done` and `busLow` are 0. `busy` rises the clock after an accepted start. `done` is high for exactly one clock, which is the first clock with `busy` low.
- R7: A `start` that arrives while `busy` is high is ignored. The running command keeps its waveform and its length.
- R8: `rdBit` changes only at the sample point of a read. `presence` changes only at the sample point of a reset. Other commands leave both unchanged.
- R9: Consecutive slots are separated by at least 5 µs with the wire released. A `start` held high is accepted one clock after `done`.
- R10: Command code 2'b11 is reserved. A `start` that carries it is ignored: `busy` stays 0 and the wire stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe |
| cmd | input | 2 | 00 reset, 01 write, 10 read, 11 reserved |
| dataBit | input | 1 | Bit to write |
| busIn | input | 1 | Level seen on the wire |
| busLow | output | 1 | Pull-down enable for the open-drain wire |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock completion pulse |
| presence | output | 1 | A slave answered the last reset |
| rdBit | output | 1 | Bit sampled by the last read |

## Verification
Command completion and command acceptance can meet at the same clock edge when the host holds `start` high while a slot finishes. The start arrives on the clock that raises `done`, so the block must accept it one clock later and only after the recovery tail. The bench holds `start` high across two write-0 slots. It then checks three things: `busy` stays low for exactly one clock, the wire stays released for at least 5 µs between the two low phases, and the second slot keeps its full length.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

  typedef enum logic [1:0] {
    CMD_RESET = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10,
    CMD_NONE  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic timerClr;
    logic sampleRead;
    logic samplePres;
  } strobes_t;

endpackage

// File: rtl/swbus_datapath.sv
module swbus_datapath
  import swbus_pkg::*;
#(
  parameter int DIV  = 50,
  parameter int US_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  input  logic            busIn,
  output logic [US_W-1:0] usCnt,
  output logic            usStep,
  output logic            rdBit,
  output logic            presence
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [US_W-1:0] US_MAX = {US_W{1'b1}};

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [1:0]       syncQ;
  logic             busS;

  assign tick = (divCnt == DIV_LAST);
  assign busS = syncQ[1];

  // microsecond timebase, restarted by the control at each command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      usCnt  <= '0;
      usStep <= 1'b0;
    end else if (strobes.timerClr) begin
      divCnt <= '0;
      usCnt  <= '0;
      usStep <= 1'b0;
    end else begin
      usStep <= tick;
      if (tick) begin
        divCnt <= '0;
        if (usCnt != US_MAX) usCnt <= usCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // two-stage synchronizer, idle level high
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], busIn};
  end

  // sample registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBit    <= 1'b0;
      presence <= 1'b0;
    end else begin
      if (strobes.sampleRead) rdBit    <= busS;
      if (strobes.samplePres) presence <= !busS;
    end
  end

  assert_pres_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.samplePres |=> $stable(presence));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleRead |=> $stable(rdBit));

  assert_timer_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.timerClr |=> (usCnt == '0) && !usStep);

endmodule

// File: rtl/swbus_control.sv
module swbus_control
  import swbus_pkg::*;
#(
  parameter int US_W           = 10,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_TOTAL_US   = 960,
  parameter int REL_US         = 6,
  parameter int READ_SAMPLE_US = 12,
  parameter int SLOT_US        = 65,
  parameter int RECOV_US       = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      cmd,
  input  logic            dataBit,
  input  logic [US_W-1:0] usCnt,
  input  logic            usStep,
  output strobes_t        strobes,
  output logic            busLow,
  output logic            busy,
  output logic            done
);

  localparam logic [US_W-1:0] PRES_AT  = US_W'(RST_LOW_US + PRES_SAMPLE_US);
  localparam logic [US_W-1:0] READ_AT  = US_W'(READ_SAMPLE_US);
  localparam logic [US_W-1:0] RST_LOW  = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] RST_END  = US_W'(RST_TOTAL_US);
  localparam logic [US_W-1:0] REL_AT   = US_W'(REL_US);
  localparam logic [US_W-1:0] SLOT_LOW = US_W'(SLOT_US);
  localparam logic [US_W-1:0] SLOT_END = US_W'(SLOT_US + RECOV_US);

  typedef enum logic {ST_IDLE, ST_ACTIVE} state_e;

  state_e          state;
  cmd_e            curCmd;
  logic            curBit;
  logic [US_W-1:0] lowEnd;
  logic [US_W-1:0] endAt;
  logic            accept;
  logic            finish;

  assign accept = (state == ST_IDLE) && start && (cmd_e'(cmd) != CMD_NONE);
  assign busy   = (state == ST_ACTIVE);

  always_comb begin
    case (curCmd)
      CMD_RESET: begin lowEnd = RST_LOW; endAt = RST_END; end
      CMD_WRITE: begin lowEnd = curBit ? REL_AT : SLOT_LOW; endAt = SLOT_END; end
      default:   begin lowEnd = REL_AT; endAt = SLOT_END; end
    endcase
  end

  assign finish = (state == ST_ACTIVE) && (usCnt == endAt);

  always_comb begin
    strobes.timerClr   = accept;
    strobes.sampleRead = (state == ST_ACTIVE) && (curCmd == CMD_READ) &&
                         usStep && (usCnt == READ_AT);
    strobes.samplePres = (state == ST_ACTIVE) && (curCmd == CMD_RESET) &&
                         usStep && (usCnt == PRES_AT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curCmd <= CMD_RESET;
      curBit <= 1'b0;
      busLow <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_ACTIVE;
            curCmd <= cmd_e'(cmd);
            curBit <= dataBit;
            busLow <= 1'b1;
          end
        end
        default: begin
          if (finish) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            busLow <= 1'b0;
          end else begin
            busLow <= (usCnt < lowEnd);
          end
        end
      endcase
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_start_takes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (cmd != 2'b11)) |=> busy && busLow);

  assert_low_in_cmd_R1: assert property (@(posedge clk) disable iff (!rstN)
    busLow |-> busy);

  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(curCmd) && $stable(curBit));

  assert_end_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done && !busLow);

  assert_reserved_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (cmd == 2'b11)) |=> !busy);

endmodule

// File: rtl/swbus_master.sv
module swbus_master
  import swbus_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_TOTAL_US   = 960,
  parameter int REL_US         = 6,
  parameter int READ_SAMPLE_US = 12,
  parameter int SLOT_US        = 65,
  parameter int RECOV_US       = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] cmd,
  input  logic       dataBit,
  input  logic       busIn,
  output logic       busLow,
  output logic       busy,
  output logic       done,
  output logic       presence,
  output logic       rdBit
);

  localparam int DIV_RAW = CLK_HZ / 1_000_000;
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int SLOT_TOTAL = SLOT_US + RECOV_US;
  localparam int MAX_US  = (RST_TOTAL_US > SLOT_TOTAL) ? RST_TOTAL_US : SLOT_TOTAL;
  localparam int US_W    = $clog2(MAX_US + 2);

  strobes_t        strobes;
  logic [US_W-1:0] usCnt;
  logic            usStep;

  swbus_control #(
    .US_W(US_W), .RST_LOW_US(RST_LOW_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .RST_TOTAL_US(RST_TOTAL_US), .REL_US(REL_US), .READ_SAMPLE_US(READ_SAMPLE_US),
    .SLOT_US(SLOT_US), .RECOV_US(RECOV_US)
  ) i_control (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .dataBit(dataBit),
    .usCnt(usCnt), .usStep(usStep), .strobes(strobes),
    .busLow(busLow), .busy(busy), .done(done)
  );

  swbus_datapath #(.DIV(DIV), .US_W(US_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busIn(busIn),
    .usCnt(usCnt), .usStep(usStep), .rdBit(rdBit), .presence(presence)
  );

endmodule

// File: tb/test_swbus_master.sv
`timescale 1ns/1ps
module test_swbus_master;

  // scaled timebase: 4 clocks per microsecond
  localparam int US = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] cmdIn = 2'b00;
  logic dataIn = 1'b0;
  logic busLow, busy, done, presence, rdBit;
  logic slaveLow = 1'b0;
  logic busLine;

  int checks = 0;
  int errors = 0;
  int slaveMode = 0;
  int sinceRise = 100000;
  int sinceFall = 100000;
  logic prevLow = 1'b0;

  assign busLine = !(busLow || slaveLow);

  swbus_master #(.CLK_HZ(US * 1_000_000)) i_swbus_master (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmdIn), .dataBit(dataIn),
    .busIn(busLine), .busLow(busLow), .busy(busy), .done(done),
    .presence(presence), .rdBit(rdBit)
  );

  always #2.5 clk = ~clk;

  // slave model: 1 presence, 2 read zero, 3 late pull-down
  always @(negedge clk) begin
    if (busLow && !prevLow) sinceRise = 0;
    else if (sinceRise < 100000) sinceRise++;
    if (!busLow && prevLow) sinceFall = 0;
    else if (sinceFall < 100000) sinceFall++;
    prevLow = busLow;
    case (slaveMode)
      1: slaveLow = (sinceFall >= 30*US) && (sinceFall < 130*US);
      2: slaveLow = (sinceRise < 20*US);
      3: slaveLow = (sinceRise >= 16*US) && (sinceRise < 30*US);
      default: slaveLow = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runCmd(input logic [1:0] c, input logic b,
                        output int lowLen, output int busyLen,
                        output int doneAtEnd, output int doneAfter);
    bit first;
    @(negedge clk);
    cmdIn = c; dataIn = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lowLen = 0; busyLen = 0; first = 1'b1;
    while (busy) begin
      if (busLow && first) lowLen++;
      else if (lowLen > 0) first = 1'b0;
      busyLen++;
      @(negedge clk);
    end
    doneAtEnd = int'(done);
    @(negedge clk);
    doneAfter = int'(done);
  endtask

  task automatic t_reset_state();
    check(!busy, "R6 busy after reset", int'(busy), 0);
    check(!busLow, "R6 busLow after reset", int'(busLow), 0);
    check(!done, "R6 done after reset", int'(done), 0);
  endtask

  task automatic t_reset_present();
    int lowLen, busyLen, d0, d1;
    slaveMode = 1;
    runCmd(2'b00, 1'b0, lowLen, busyLen, d0, d1);
    check(lowLen == 480*US + 1, "R1 reset low length", lowLen, 480*US + 1);
    check(busyLen == 960*US + 1, "R1 reset busy length", busyLen, 960*US + 1);
    check(d0 == 1 && d1 == 0, "R6 done single pulse", d0*10 + d1, 10);
    check(presence, "R2 presence seen", int'(presence), 1);
    slaveMode = 0;
  endtask

  task automatic t_reset_absent();
    int lowLen, busyLen, d0, d1;
    slaveMode = 0;
    runCmd(2'b00, 1'b0, lowLen, busyLen, d0, d1);
    check(!presence, "R2 presence absent", int'(presence), 0);
  endtask

  task automatic t_write1();
    int lowLen, busyLen, d0, d1;
    logic presBefore;
    presBefore = presence;
    runCmd(2'b01, 1'b1, lowLen, busyLen, d0, d1);
    check(lowLen == 6*US + 1, "R3 write1 low length", lowLen, 6*US + 1);
    check(busyLen == 70*US + 1, "R3 write1 slot length", busyLen, 70*US + 1);
    check(presence == presBefore, "R8 presence kept by write", int'(presence), int'(presBefore));
  endtask

  task automatic t_write0();
    int lowLen, busyLen, d0, d1;
    runCmd(2'b01, 1'b0, lowLen, busyLen, d0, d1);
    check(lowLen == 65*US + 1, "R4 write0 low length", lowLen, 65*US + 1);
    check(busyLen == 70*US + 1, "R4 write0 slot length", busyLen, 70*US + 1);
    check(d0 == 1, "R6 done at write0 end", d0, 1);
  endtask

  task automatic t_read();
    int lowLen, busyLen, d0, d1;
    logic presBefore;
    slaveMode = 0;
    runCmd(2'b10, 1'b0, lowLen, busyLen, d0, d1);
    check(rdBit, "R5 read high gives 1", int'(rdBit), 1);
    check(lowLen == 6*US + 1, "R5 read low length", lowLen, 6*US + 1);
    slaveMode = 2;
    presBefore = presence;
    runCmd(2'b10, 1'b0, lowLen, busyLen, d0, d1);
    check(!rdBit, "R5 read low gives 0", int'(rdBit), 0);
    check(presence == presBefore, "R8 presence kept by read", int'(presence), int'(presBefore));
    slaveMode = 0;
    // rdBit must survive a write
    runCmd(2'b01, 1'b1, lowLen, busyLen, d0, d1);
    check(!rdBit, "R8 rdBit kept by write", int'(rdBit), 0);
    slaveMode = 3;
    runCmd(2'b10, 1'b0, lowLen, busyLen, d0, d1);
    check(rdBit, "R5 late pull-down reads 1", int'(rdBit), 1);
    slaveMode = 0;
  endtask

  task automatic t_ignore_busy();
    int busyLen = 0;
    int lowLen = 0;
    @(negedge clk);
    cmdIn = 2'b01; dataIn = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) begin
      busyLen++;
      if (busLow) lowLen++;
      if (busyLen == 40) begin cmdIn = 2'b00; start = 1'b1; end
      if (busyLen == 41) start = 1'b0;
      @(negedge clk);
    end
    check(busyLen == 70*US + 1, "R7 busy start ignored length", busyLen, 70*US + 1);
    check(lowLen == 6*US + 1, "R7 busy start ignored waveform", lowLen, 6*US + 1);
    repeat (3) @(negedge clk);
    check(!busy, "R7 no queued command", int'(busy), 0);
  endtask

  task automatic t_reserved();
    int seen = 0;
    @(negedge clk);
    cmdIn = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy || busLow) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10 reserved code ignored", seen, 0);
  endtask

  task automatic t_back_to_back();
    int idle = 0;
    int gap = 0;
    int lowLen = 0;
    int busyLen = 0;
    @(negedge clk);
    cmdIn = 2'b01; dataIn = 1'b0; start = 1'b1;
    @(negedge clk);
    while (busy) @(negedge clk);
    while (!busy) begin idle++; @(negedge clk); end
    start = 1'b0;
    check(idle == 1, "R9 idle clocks between slots", idle, 1);
    // measure second slot; gap measured from end of first low phase separately below
    while (busy) begin
      busyLen++;
      if (busLow) lowLen++;
      @(negedge clk);
    end
    check(busyLen == 70*US + 1, "R9 second slot length", busyLen, 70*US + 1);
    check(lowLen == 65*US + 1, "R9 second slot low length", lowLen, 65*US + 1);
    // gap: repeat with a released-time count between low phases
    @(negedge clk);
    cmdIn = 2'b01; dataIn = 1'b0; start = 1'b1;
    @(negedge clk);
    while (busLow) @(negedge clk);
    while (!busLow) begin gap++; @(negedge clk); end
    start = 1'b0;
    check(gap >= 5*US, "R9 recovery gap", gap, 5*US);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_present();
    t_write1();
    t_write0();
    t_read();
    t_reset_absent();
    t_ignore_busy();
    t_reserved();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule